// File: doc/BRIEF.md
# Complex Givens CORDIC Cell

This cell performs one complex Givens rotation on a pair of complex operands, a diagonal element `r` and an off-diagonal element `x`. Three shift-and-add CORDIC datapaths do the work. The first stage turns `x` onto the real axis, which removes its phase. The second stage applies a real rotation to the real parts and, in step with it, to the imaginary parts. Each stage runs 16 iterations, and each iteration is decided by one direction bit.

In vectoring mode the cell annihilates `x` against the real diagonal `r`. It records two direction-bit codes, one per stage. Each code carries a leading half-turn flag so that operands in any quadrant converge. In rotation mode the cell replays the stored codes on a new complex pair. This lets one cell serve a whole row of a triangular array on a time-shared basis.

CORDIC gain is left uncompensated. Each stage scales its outputs by G = ∏(i=0..15) √(1+2^-2i) ≈ 1.6468. Because the second stage sees the first stage's output, `x` enters the second stage scaled by G, and all results carry one further factor G.

Top module: `cgivens_cordic_cell`

## Requirements
- R1: After reset, `out_en` is low and all four result outputs are zero.
- R2: With `vec_mode`=1, the result has `out_r_re` ≈ G·√(r_re² + G²·(x_re²+x_im²)) and `out_r_re` ≥ 0. The outputs `out_x_re`, `out_x_im` and `out_r_im` are ≈ 0, within a few tens of LSB.
- R3: Vectoring converges for operands in every quadrant, including a negative `r_re` and a negative `x_re`.
- R4: With `vec_mode`=0, using the stored angles φ and θ, the cell first forms x' = G·x·e^(−jφ). It then outputs r_out = G·(r·cosθ + x'·sinθ) and x_out = G·(x'·cosθ − r·sinθ). This is applied separately to the real parts and to the imaginary parts.
- R5: The rotation codes change only in vectoring operations. Any number of rotation operations reuse the codes of the last accepted vectoring operation.
- R6: In vectoring mode `r_im` is ignored and treated as zero.
- R7: `out_en` is high for exactly one cycle, following the 34th rising edge after the edge that accepts `start`. The result outputs change only on that edge.
- R8: A `start` that arrives while an operation is in progress is ignored, including in the cycle the result is being registered. Such a `start` produces no result and does not disturb the stored codes.
- R9: A vectoring operation with x = 0 yields `out_r_re` ≈ G·|r_re|.

All operand components are assumed to lie within ±2^17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation when the cell is idle |
| vec_mode | input | 1 | 1 = vectoring (store codes), 0 = rotation (replay codes) |
| r_re | input | 22 | Diagonal operand, real part (signed) |
| r_im | input | 22 | Diagonal operand, imaginary part (signed) |
| x_re | input | 22 | Off-diagonal operand, real part (signed) |
| x_im | input | 22 | Off-diagonal operand, imaginary part (signed) |
| out_en | output | 1 | One-cycle result qualifier |
| out_r_re | output | 22 | Rotated diagonal, real part |
| out_r_im | output | 22 | Rotated diagonal, imaginary part |
| out_x_re | output | 22 | Rotated off-diagonal, real part |
| out_x_im | output | 22 | Rotated off-diagonal, imaginary part |

## Verification
Result delivery and acceptance of a new request collide at the end of an operation. A `start` pulse is placed in the very cycle the result is being registered, and it must vanish without trace. A second pulse is placed in the cycle where `out_en` is visible, and it must be accepted with the full 34-edge latency. The scoreboard judges both. It flags any result it did not expect, and it compares every expected result against a floating-point model of the two gain-scaled rotations within a fixed tolerance. A vectoring request rejected mid-operation is followed by rotation requests, which shows that the codes it could have overwritten are still the earlier ones.

// File: rtl/cgivens_cordic_cell.sv
module cgivens_cordic_cell #(
  parameter int DW  = 22,
  parameter int NIT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 vec_mode,
  input  logic signed [DW-1:0] r_re,
  input  logic signed [DW-1:0] r_im,
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  output logic                 out_en,
  output logic signed [DW-1:0] out_r_re,
  output logic signed [DW-1:0] out_r_im,
  output logic signed [DW-1:0] out_x_re,
  output logic signed [DW-1:0] out_x_im
);
  localparam int CW = $clog2(NIT);
  localparam logic [CW-1:0] LAST = CW'(NIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_PHI, S_LDT, S_THT, S_FIN} st_t;
  st_t st;

  logic                 mode_q;
  logic [CW-1:0]        cnt;
  logic [NIT-1:0]       phi_code, th_code;
  logic                 phi_neg, th_neg;
  logic signed [DW-1:0] px, py, ar, br, ai, bi;

  // one direction bit per stage: 1 = rotate clockwise (drive the second coordinate down)
  logic sp, stt, neg_p, neg_t;
  assign sp    = mode_q ? ~py[DW-1] : phi_code[cnt];
  assign stt   = mode_q ? ~br[DW-1] : th_code[cnt];
  assign neg_p = vec_mode ? x_re[DW-1] : phi_neg;
  assign neg_t = mode_q ? ar[DW-1] : th_neg;

  logic signed [DW-1:0] px_n, py_n, ar_n, br_n, ai_n, bi_n;
  assign px_n = sp  ? px + (py >>> cnt) : px - (py >>> cnt);
  assign py_n = sp  ? py - (px >>> cnt) : py + (px >>> cnt);
  assign ar_n = stt ? ar + (br >>> cnt) : ar - (br >>> cnt);
  assign br_n = stt ? br - (ar >>> cnt) : br + (ar >>> cnt);
  assign ai_n = stt ? ai + (bi >>> cnt) : ai - (bi >>> cnt);
  assign bi_n = stt ? bi - (ai >>> cnt) : bi + (ai >>> cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= 1'b0;
      cnt      <= '0;
      phi_code <= '0;
      th_code  <= '0;
      phi_neg  <= 1'b0;
      th_neg   <= 1'b0;
      px       <= '0;
      py       <= '0;
      ar       <= '0;
      br       <= '0;
      ai       <= '0;
      bi       <= '0;
      out_en   <= 1'b0;
      out_r_re <= '0;
      out_r_im <= '0;
      out_x_re <= '0;
      out_x_im <= '0;
    end else begin
      out_en <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q <= vec_mode;
          if (vec_mode) phi_neg <= x_re[DW-1];
          px  <= neg_p ? -x_re : x_re;
          py  <= neg_p ? -x_im : x_im;
          ar  <= r_re;
          ai  <= vec_mode ? '0 : r_im;
          cnt <= '0;
          st  <= S_PHI;
        end
        S_PHI: begin
          px <= px_n;
          py <= py_n;
          if (mode_q) phi_code[cnt] <= sp;
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= S_LDT;
          end else cnt <= cnt + 1'b1;
        end
        S_LDT: begin
          if (mode_q) th_neg <= ar[DW-1];
          ar <= neg_t ? -ar : ar;
          ai <= neg_t ? -ai : ai;
          br <= neg_t ? -px : px;
          bi <= neg_t ? -py : py;
          st <= S_THT;
        end
        S_THT: begin
          ar <= ar_n;
          br <= br_n;
          ai <= ai_n;
          bi <= bi_n;
          if (mode_q) th_code[cnt] <= stt;
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= S_FIN;
          end else cnt <= cnt + 1'b1;
        end
        S_FIN: begin
          out_r_re <= ar;
          out_r_im <= ai;
          out_x_re <= br;
          out_x_im <= bi;
          out_en   <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_outen_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> !out_en);

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> ($stable(out_r_re) && $stable(out_r_im) && $stable(out_x_re) && $stable(out_x_im)));

  a_r2_vec_residual: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode_q) |-> (out_x_re < 256 && out_x_re > -256 && out_x_im < 256 && out_x_im > -256
                            && out_r_im < 256 && out_r_im > -256));

  a_r2_vec_rpos: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode_q) |-> !out_r_re[DW-1]);

  a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !mode_q) |=> ($stable(phi_code) && $stable(th_code)));

  a_r8_busy_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(mode_q));
endmodule

// File: tb/cgivens_cordic_cell_tb.sv
`timescale 1ns/1ps
module cgivens_cordic_cell_tb;
  localparam int  DW  = 22;
  localparam int  LAT = 35;
  localparam real TOL = 64.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vec_mode = 1'b0;
  logic signed [DW-1:0] r_re = '0, r_im = '0, x_re = '0, x_im = '0;
  logic out_en;
  logic signed [DW-1:0] out_r_re, out_r_im, out_x_re, out_x_im;

  cgivens_cordic_cell #(.DW(DW), .NIT(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_mode(vec_mode),
    .r_re(r_re), .r_im(r_im), .x_re(x_re), .x_im(x_im),
    .out_en(out_en), .out_r_re(out_r_re), .out_r_im(out_r_im),
    .out_x_re(out_x_re), .out_x_im(out_x_im));

  always #2.5 clk = ~clk;

  int  cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;
  real gain;
  real phi_s = 0.0, th_s = 0.0;

  real   q_rre[$], q_rim[$], q_xre[$], q_xim[$];
  int    q_t0[$];
  string q_tag[$];

  task automatic chk(string tag, real act, real expv, real tol);
    n_chk++;
    if ((act - expv > tol) || (expv - act > tol)) begin
      n_fail++;
      $display("FAIL %s: actual %0f expected %0f", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_en) begin
      if (q_tag.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R8 unexpected result: actual out_en=1 expected 0");
      end else begin
        automatic string tg = q_tag.pop_front();
        automatic real e_rre = q_rre.pop_front();
        automatic real e_rim = q_rim.pop_front();
        automatic real e_xre = q_xre.pop_front();
        automatic real e_xim = q_xim.pop_front();
        automatic int  t0 = q_t0.pop_front();
        chk({tg, " out_r_re"}, real'(out_r_re), e_rre, TOL);
        chk({tg, " out_r_im"}, real'(out_r_im), e_rim, TOL);
        chk({tg, " out_x_re"}, real'(out_x_re), e_xre, TOL);
        chk({tg, " out_x_im"}, real'(out_x_im), e_xim, TOL);
        chk({tg, " R7 latency"}, real'(cyc - t0), real'(LAT), 0.0);
      end
    end
  end

  // driver: called at a negedge, returns one negedge later
  task automatic issue(bit v, int rr, int ri, int xr, int xi, bit push, string tag);
    real m, xpr, xpi, rim;
    vec_mode = v;
    r_re = DW'(rr); r_im = DW'(ri); x_re = DW'(xr); x_im = DW'(xi);
    start = 1'b1;
    if (push) begin
      if (v) begin
        phi_s = $atan2(real'(xi), real'(xr));
        m     = gain * $sqrt(real'(xr) * real'(xr) + real'(xi) * real'(xi));
        th_s  = $atan2(m, real'(rr));
        q_rre.push_back(gain * $sqrt(real'(rr) * real'(rr) + m * m));
        q_rim.push_back(0.0);
        q_xre.push_back(0.0);
        q_xim.push_back(0.0);
      end else begin
        rim = real'(ri);
        xpr = gain * (real'(xr) * $cos(phi_s) + real'(xi) * $sin(phi_s));
        xpi = gain * (real'(xi) * $cos(phi_s) - real'(xr) * $sin(phi_s));
        q_rre.push_back(gain * (real'(rr) * $cos(th_s) + xpr * $sin(th_s)));
        q_xre.push_back(gain * (xpr * $cos(th_s) - real'(rr) * $sin(th_s)));
        q_rim.push_back(gain * (rim * $cos(th_s) + xpi * $sin(th_s)));
        q_xim.push_back(gain * (xpi * $cos(th_s) - rim * $sin(th_s)));
      end
      q_t0.push_back(cyc);
      q_tag.push_back(tag);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_out();
    while (!out_en) @(negedge clk);
  endtask

  initial begin
    gain = 1.0;
    for (int i = 0; i < 16; i++) gain = gain * $sqrt(1.0 + 1.0 / (4.0 ** i));

    repeat (3) @(negedge clk);
    chk("R1 reset out_en", real'(out_en), 0.0, 0.0);
    chk("R1 reset out_r_re", real'(out_r_re), 0.0, 0.0);
    chk("R1 reset out_x_im", real'(out_x_im), 0.0, 0.0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(1'b1, 60000, 0, 30000, 40000, 1'b1, "R2 vectoring basic");
    wait_out();
    issue(1'b0, 20000, -15000, 50000, 10000, 1'b1, "R4 rotation A");
    wait_out();
    issue(1'b0, -70000, 33000, -12000, 90000, 1'b1, "R5 rotation reuse");
    wait_out();
    @(negedge clk);

    issue(1'b1, -50000, 0, -80000, -20000, 1'b1, "R3 vectoring negative quadrant");
    wait_out();
    issue(1'b0, 40000, 25000, -30000, 60000, 1'b1, "R3 rotation after negative vectoring");
    wait_out();
    @(negedge clk);

    issue(1'b1, 45000, 99000, -25000, 35000, 1'b1, "R6 vectoring r_im ignored");
    wait_out();
    @(negedge clk);

    // R8: a vectoring start mid-operation is dropped and leaves the codes alone
    issue(1'b1, 90000, 0, 10000, -70000, 1'b1, "R8 vectoring kept");
    repeat (4) @(negedge clk);
    issue(1'b1, -100000, 0, 5000, 5000, 1'b0, "");
    wait_out();
    issue(1'b0, 30000, -40000, 70000, 20000, 1'b1, "R8 rotation uses kept codes");
    wait_out();
    @(negedge clk);

    // R8/R7: start in the registering cycle is ignored; start while out_en shows is accepted
    issue(1'b0, -20000, 10000, 15000, -65000, 1'b1, "R7 rotation timed");
    repeat (33) @(negedge clk);
    issue(1'b1, 80000, 0, 80000, 80000, 1'b0, "");
    wait_out();
    issue(1'b0, 55000, 5000, -45000, -35000, 1'b1, "R7 back-to-back rotation");
    wait_out();
    @(negedge clk);

    issue(1'b1, -75000, 0, 0, 0, 1'b1, "R9 vectoring zero x");
    wait_out();

    repeat (60) @(negedge clk);
    chk("R8 no pending or extra results", real'(q_tag.size()), 0.0, 0.0);
    chk("R7 out_en low when idle", real'(out_en), 0.0, 0.0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule